// File: doc/BRIEF.md
# Dual-Half General Purpose Timer

A register-mapped timer built from two 16-bit halves. Software selects how the halves are combined. In the first mode they form one 32-bit down-counter that reloads or stops at timeout. In the second they form a 32-bit up-counter that advances on a one-cycle `rtc_tick` enable and flags a match against a 32-bit compare value. Half A has a programmable prescaler that divides the countdown rate. A level interrupt reports masked status. An optional one-cycle pulse on every countdown timeout can start an ADC conversion.

The bus is a plain single-cycle write strobe with a combinational read. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure: each write takes effect at the clock edge where `bus_wr` is high. Split 16-bit operation (capture and PWM) is not provided. Asking for it raises an error status bit instead of changing the timer.

Top module: `gpt_dual_timer`

## Requirements
- R1: After reset every register reads 0, and `irq` and `adc_trig` are low.
- R2: When config (offset 0x00) is 0 and control bit 0 goes from 0 to 1, the count (read at 0x48) loads the reload value `{B,A}` and restarts the prescaler. The count then drops by one every (prescale A + 1) clocks. A prescaler step taken while the count is 1 or 0 is a timeout, and the timeout sets raw status bit 0.
- R3: Mode A (offset 0x04) bit 0 set means one-shot: a timeout clears control bit 0 and leaves the count at 0. Mode A bit 0 clear means periodic: a timeout reloads `{B,A}`. A control write in the same cycle takes priority over the one-shot clear.
- R4: `adc_trig` is high for exactly the one cycle after a countdown timeout, and only when control bit 5 is set. RTC mode never pulses it.
- R5: When config is 1 and control bit 0 is set, each `rtc_tick` cycle adds one to the RTC count (read at 0x48). When the new count equals `{match B, match A}`, raw status bit 1 is set. With the timer disabled, the tick has no effect.
- R6: A write to the mask register (0x18) keeps only the bits in 0x77. The raw status (0x1C) holds bit 0 (timeout), bit 1 (RTC match) and bit 2 (error). 0x20 reads raw AND mask, and `irq` is high whenever that value is nonzero.
- R7: Writing 1s to 0x24 clears those raw status bits. A bit that is being set in the same cycle stays set.
- R8: A write to 0x28 (or 0x30) stores bits 15:0 in half A. It also stores bits 31:16 in half B, but only when config is below 4. Reading 0x28 (or 0x30) shows half B in bits 31:16 only when config is below 4. 0x2C and 0x34 write and read half B alone from bits 15:0.
- R9: Any unsupported write sets raw status bit 2 and leaves the field unchanged. This covers a config value other than 0, 1 or 4, a mode value with any of bits 3:1 set (offsets 0x04 and 0x08), and a control write that sets bit 0 or bit 8 while config is 4. In that last case the rest of the control word is stored with both enable bits cleared.
- R10: Clearing control bit 0 freezes the count. Setting it again reloads `{B,A}`.
- R11: The prescale registers (0x38, 0x3C) and the prescale-match registers (0x40, 0x44) store and return 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 2*HALF_W | Write data |
| bus_rdata | output | 2*HALF_W | Read data for `bus_addr`, combinational |
| rtc_tick | input | 1 | One-cycle enable that advances the RTC count |
| irq | output | 1 | Level interrupt: raw AND mask is nonzero |
| adc_trig | output | 1 | One-cycle pulse after a countdown timeout |

## Verification
The bench uses the default parameters: 16-bit halves and an 8-bit prescaler. The 32-bit datapath and the upper-half visibility rule are therefore exercised at their real width. Small reload and prescale values make several periodic timeouts, one-shot stops and back-to-back timeouts happen within a few dozen cycles. Reload 1 with prescale 0 gives a timeout on every clock, which puts the clear-versus-set collision within reach. Config value 4 is written on purpose so that the hidden upper half and the refused enable can be observed.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int ADDR_W = 8;
  localparam int MODE_W = 4;
  localparam int CTRL_W = 9;
  localparam int ST_W   = 7;

  localparam logic [ADDR_W-1:0] OFF_CFG     = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MODE_A  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_MASK    = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_RAW     = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_MSTAT   = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CLR     = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_LOAD_A  = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_LOAD_B  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_MATCH_A = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_MATCH_B = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_PRE_A   = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_PMT_A   = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_VALUE   = 8'h48;

  typedef logic [2:0] cfg_t;
  localparam cfg_t CFG_CAT32 = 3'd0;
  localparam cfg_t CFG_RTC   = 3'd1;
  localparam cfg_t CFG_SPLIT = 3'd4;

  localparam int CB_EN_A = 0;
  localparam int CB_TRIG = 5;
  localparam int CB_EN_B = 8;

  localparam int ST_TIMEOUT = 0;
  localparam int ST_MATCH   = 1;
  localparam int ST_ERR     = 2;
  localparam logic [ST_W-1:0] MASK_KEEP = 7'h77;

  function automatic logic cfg_ok(input cfg_t v);
    return (v == CFG_CAT32) || (v == CFG_RTC) || (v == CFG_SPLIT);
  endfunction
endpackage

// File: rtl/gpt_countdown.sv
module gpt_countdown #(
  parameter int W     = 32,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic [W-1:0]     reload,
  input  logic [PRE_W-1:0] pre_lim,
  input  logic             oneshot,
  output logic             timeout,
  output logic [W-1:0]     count_o
);
  logic [W-1:0]     cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             step;

  assign step    = run && !start && (pre_q == pre_lim);
  assign timeout = step && (cnt_q <= W'(1));
  assign count_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (start) begin
      cnt_q <= reload;
      pre_q <= '0;
    end else if (run) begin
      pre_q <= step ? '0 : pre_q + 1'b1;
      if (step) cnt_q <= timeout ? (oneshot ? '0 : reload) : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/gpt_rtc.sv
module gpt_rtc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] match_val,
  output logic         hit,
  output logic [W-1:0] count_o
);
  logic [W-1:0] rtc_q;
  logic [W-1:0] nxt;

  assign nxt     = rtc_q + 1'b1;
  assign hit     = run && tick && (nxt == match_val);
  assign count_o = rtc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rtc_q <= '0;
    else if (run && tick) rtc_q <= nxt;
  end

  // R5: without an enabled tick the count does not move
  p_rtc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && tick) |=> $stable(rtc_q))
    else $error("p_rtc_hold_r5");
endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int PRE_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*HALF_W-1:0] wdata,
  output logic [2*HALF_W-1:0] rdata,
  input  logic                set_timeout,
  input  logic                set_match,
  input  logic [2*HALF_W-1:0] cnt_val,
  input  logic [2*HALF_W-1:0] rtc_val,
  output cfg_t                cfg_o,
  output logic                en_a,
  output logic                trig_en,
  output logic                oneshot,
  output logic                start_a,
  output logic [2*HALF_W-1:0] reload,
  output logic [2*HALF_W-1:0] match32,
  output logic [PRE_W-1:0]    pre_a,
  output logic [ST_W-1:0]     raw_o,
  output logic [ST_W-1:0]     mask_o
);
  localparam int FULL_W = 2 * HALF_W;

  cfg_t              cfg_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_wv;
  logic [HALF_W-1:0] load_a, load_b, match_a, match_b;
  logic [ST_W-1:0]   raw_q, mask_q, clr_v, set_v;
  logic [PRE_W-1:0]  pre_v [2];
  logic [PRE_W-1:0]  pmt_v [2];
  logic [MODE_W-1:0] mode_v [2];
  logic [1:0]        mode_bad;
  logic              wr_cfg, wr_ctrl, cfg_bad, ctrl_bad, err_any, split, wide;

  assign split    = (cfg_q == CFG_SPLIT);
  assign wide     = (cfg_q < 3'd4);
  assign wr_cfg   = wr && (addr == OFF_CFG);
  assign wr_ctrl  = wr && (addr == OFF_CTRL);
  assign cfg_bad  = wr_cfg && !cfg_ok(wdata[2:0]);
  assign ctrl_bad = wr_ctrl && split && (wdata[CB_EN_A] || wdata[CB_EN_B]);
  assign err_any  = cfg_bad || ctrl_bad || (|mode_bad);

  always_comb begin
    ctrl_wv = '0;
    ctrl_wv[CB_EN_A] = wdata[CB_EN_A] && !split;
    ctrl_wv[CB_TRIG] = wdata[CB_TRIG];
    ctrl_wv[CB_EN_B] = wdata[CB_EN_B] && !split;
  end

  assign start_a = wr_ctrl && ctrl_wv[CB_EN_A] && !ctrl_q[CB_EN_A];

  // per-half storage: mode, prescale, prescale match
  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [ADDR_W-1:0] MODE_OFF = OFF_MODE_A + ADDR_W'(4 * h);
    localparam logic [ADDR_W-1:0] PRE_OFF  = OFF_PRE_A + ADDR_W'(4 * h);
    localparam logic [ADDR_W-1:0] PMT_OFF  = OFF_PMT_A + ADDR_W'(4 * h);
    logic [MODE_W-1:0] mode_r;
    logic [PRE_W-1:0]  pre_r, pmt_r;
    logic              wr_mode;

    assign wr_mode     = wr && (addr == MODE_OFF);
    assign mode_bad[h] = wr_mode && (wdata[MODE_W-1:1] != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_r <= '0;
        pre_r  <= '0;
        pmt_r  <= '0;
      end else begin
        if (wr_mode && !mode_bad[h])    mode_r <= wdata[MODE_W-1:0];
        if (wr && (addr == PRE_OFF))    pre_r  <= wdata[PRE_W-1:0];
        if (wr && (addr == PMT_OFF))    pmt_r  <= wdata[PRE_W-1:0];
      end
    end
    assign mode_v[h] = mode_r;
    assign pre_v[h]  = pre_r;
    assign pmt_v[h]  = pmt_r;
  end

  assign clr_v = (wr && (addr == OFF_CLR)) ? wdata[ST_W-1:0] : '0;
  always_comb begin
    set_v = '0;
    set_v[ST_TIMEOUT] = set_timeout;
    set_v[ST_MATCH]   = set_match;
    set_v[ST_ERR]     = err_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_CAT32;
      ctrl_q  <= '0;
      load_a  <= '0;
      load_b  <= '0;
      match_a <= '0;
      match_b <= '0;
      mask_q  <= '0;
      raw_q   <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_v) | set_v;
      if (wr_cfg && !cfg_bad) cfg_q <= wdata[2:0];
      if (wr_ctrl) ctrl_q <= ctrl_wv;
      else if (set_timeout && oneshot) ctrl_q[CB_EN_A] <= 1'b0;
      if (wr && (addr == OFF_MASK)) mask_q <= wdata[ST_W-1:0] & MASK_KEEP;
      if (wr && (addr == OFF_LOAD_A)) begin
        load_a <= wdata[HALF_W-1:0];
        if (wide) load_b <= wdata[FULL_W-1:HALF_W];
      end
      if (wr && (addr == OFF_LOAD_B)) load_b <= wdata[HALF_W-1:0];
      if (wr && (addr == OFF_MATCH_A)) begin
        match_a <= wdata[HALF_W-1:0];
        if (wide) match_b <= wdata[FULL_W-1:HALF_W];
      end
      if (wr && (addr == OFF_MATCH_B)) match_b <= wdata[HALF_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_CFG:              rdata = FULL_W'(cfg_q);
      OFF_MODE_A:           rdata = FULL_W'(mode_v[0]);
      OFF_MODE_A + 8'h04:   rdata = FULL_W'(mode_v[1]);
      OFF_CTRL:             rdata = FULL_W'(ctrl_q);
      OFF_MASK:             rdata = FULL_W'(mask_q);
      OFF_RAW:              rdata = FULL_W'(raw_q);
      OFF_MSTAT:            rdata = FULL_W'(raw_q & mask_q);
      OFF_LOAD_A:           rdata = {wide ? load_b : '0, load_a};
      OFF_LOAD_B:           rdata = FULL_W'(load_b);
      OFF_MATCH_A:          rdata = {wide ? match_b : '0, match_a};
      OFF_MATCH_B:          rdata = FULL_W'(match_b);
      OFF_PRE_A:            rdata = FULL_W'(pre_v[0]);
      OFF_PRE_A + 8'h04:    rdata = FULL_W'(pre_v[1]);
      OFF_PMT_A:            rdata = FULL_W'(pmt_v[0]);
      OFF_PMT_A + 8'h04:    rdata = FULL_W'(pmt_v[1]);
      OFF_VALUE:            rdata = (cfg_q == CFG_RTC) ? rtc_val : cnt_val;
      default:              rdata = '0;
    endcase
  end

  assign cfg_o   = cfg_q;
  assign en_a    = ctrl_q[CB_EN_A];
  assign trig_en = ctrl_q[CB_TRIG];
  assign oneshot = mode_v[0][0];
  assign reload  = {load_b, load_a};
  assign match32 = {match_b, match_a};
  assign pre_a   = pre_v[0];
  assign raw_o   = raw_q;
  assign mask_o  = mask_q;

  // R9: a refused config write flags an error and keeps the old config
  p_bad_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !cfg_ok(wdata[2:0])) |=> (raw_q[ST_ERR] && $stable(cfg_q)))
    else $error("p_bad_cfg_r9");

  // R7: clearing the timeout bit works when no timeout collides
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (addr == OFF_CLR) && wdata[ST_TIMEOUT] && !set_timeout) |=> !raw_q[ST_TIMEOUT])
    else $error("p_clear_r7");
endmodule

// File: rtl/gpt_dual_timer.sv
module gpt_dual_timer
  import gpt_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int PRE_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [7:0]          bus_addr,
  input  logic [2*HALF_W-1:0] bus_wdata,
  output logic [2*HALF_W-1:0] bus_rdata,
  input  logic                rtc_tick,
  output logic                irq,
  output logic                adc_trig
);
  localparam int FULL_W = 2 * HALF_W;

  cfg_t              cfg;
  logic              en_a, trig_en, oneshot, start_a, timeout, hit, trig_q;
  logic [FULL_W-1:0] reload, match32, cnt, rtc;
  logic [PRE_W-1:0]  pre_a;
  logic [ST_W-1:0]   raw, mask;

  gpt_regs #(.HALF_W(HALF_W), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .set_timeout(timeout), .set_match(hit),
    .cnt_val(cnt), .rtc_val(rtc), .cfg_o(cfg), .en_a(en_a), .trig_en(trig_en),
    .oneshot(oneshot), .start_a(start_a), .reload(reload), .match32(match32),
    .pre_a(pre_a), .raw_o(raw), .mask_o(mask)
  );

  gpt_countdown #(.W(FULL_W), .PRE_W(PRE_W)) u_cd (
    .clk(clk), .rst_n(rst_n), .run(en_a && (cfg == CFG_CAT32)), .start(start_a),
    .reload(reload), .pre_lim(pre_a), .oneshot(oneshot),
    .timeout(timeout), .count_o(cnt)
  );

  gpt_rtc #(.W(FULL_W)) u_rtc (
    .clk(clk), .rst_n(rst_n), .run(en_a && (cfg == CFG_RTC)), .tick(rtc_tick),
    .match_val(match32), .hit(hit), .count_o(rtc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= timeout && trig_en;
  end

  assign adc_trig = trig_q;
  assign irq      = |(raw & mask);

  // R4: a trigger pulse only follows a cycle spent in countdown mode
  p_trig_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> $past(cfg == CFG_CAT32))
    else $error("p_trig_cfg_r4");

  // R3: one-shot timeout drops the enable unless software writes control
  p_oneshot_halts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && oneshot && !(bus_wr && bus_addr == OFF_CTRL)) |=> !en_a)
    else $error("p_oneshot_halts_r3");

  // R6: the interrupt rises only after an event or a bus write
  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(timeout || hit || bus_wr))
    else $error("p_irq_cause_r6");
endmodule

// File: tb/test_gpt_dual_timer.sv
`timescale 1ns/1ps
module test_gpt_dual_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rtc_tick = 1'b0;
  logic        irq, adc_trig;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  logic [2:0]  m_cfg;
  logic [8:0]  m_ctrl;
  logic [3:0]  m_mode [2];
  logic [15:0] m_load [2];
  logic [15:0] m_match [2];
  logic [7:0]  m_pre [2];
  logic [7:0]  m_pm [2];
  logic [6:0]  m_mask, m_raw;
  logic [31:0] m_cnt, m_rtc;
  logic [7:0]  m_pc;
  logic        m_trig;

  always #2.5 clk = ~clk;

  gpt_dual_timer i_gpt_dual_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rtc_tick(rtc_tick),
    .irq(irq), .adc_trig(adc_trig)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return {29'b0, m_cfg};
      8'h04: return {28'b0, m_mode[0]};
      8'h08: return {28'b0, m_mode[1]};
      8'h0C: return {23'b0, m_ctrl};
      8'h18: return {25'b0, m_mask};
      8'h1C: return {25'b0, m_raw};
      8'h20: return {25'b0, m_raw & m_mask};
      8'h28: return {(m_cfg < 4) ? m_load[1] : 16'h0, m_load[0]};
      8'h2C: return {16'b0, m_load[1]};
      8'h30: return {(m_cfg < 4) ? m_match[1] : 16'h0, m_match[0]};
      8'h34: return {16'b0, m_match[1]};
      8'h38: return {24'b0, m_pre[0]};
      8'h3C: return {24'b0, m_pre[1]};
      8'h40: return {24'b0, m_pm[0]};
      8'h44: return {24'b0, m_pm[1]};
      8'h48: return (m_cfg == 3'd1) ? m_rtc : m_cnt;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h08: return "R9";
      8'h0C: return "R3";
      8'h18, 8'h1C, 8'h20: return "R6";
      8'h24: return "R7";
      8'h28, 8'h2C, 8'h30, 8'h34: return "R8";
      8'h38, 8'h3C, 8'h40, 8'h44: return "R11";
      8'h48: return (m_cfg == 3'd1) ? "R5" : "R2";
      default: return "R1";
    endcase
  endfunction

  task automatic model_reset();
    m_cfg = 0; m_ctrl = 0; m_mask = 0; m_raw = 0; m_cnt = 0; m_rtc = 0; m_pc = 0; m_trig = 0;
    for (int h = 0; h < 2; h++) begin
      m_mode[h] = 0; m_load[h] = 0; m_match[h] = 0; m_pre[h] = 0; m_pm[h] = 0;
    end
  endtask

  // one clock: drive, predict, compare every output
  task automatic step(input bit w, input logic [7:0] a, input logic [31:0] d, input bit t);
    logic [2:0]  ncfg;
    logic [8:0]  nctrl, v;
    logic [3:0]  nmode [2];
    logic [15:0] nload [2];
    logic [15:0] nmatch [2];
    logic [7:0]  npre [2];
    logic [7:0]  npm [2];
    logic [6:0]  nmask, clr;
    logic [31:0] ncnt, nrtc, rl;
    logic [7:0]  npc;
    bit err, start, to, hit, cw;
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d; rtc_tick = t;
    ncfg = m_cfg; nctrl = m_ctrl; nmask = m_mask; ncnt = m_cnt; nrtc = m_rtc; npc = m_pc;
    nmode = m_mode; nload = m_load; nmatch = m_match; npre = m_pre; npm = m_pm;
    err = 0; start = 0; to = 0; hit = 0; cw = 0; clr = 0;
    if (w) begin
      case (a)
        8'h00: if (d[2:0] == 0 || d[2:0] == 1 || d[2:0] == 4) ncfg = d[2:0]; else err = 1;
        8'h04: if (d[3:1] != 0) err = 1; else nmode[0] = d[3:0];
        8'h08: if (d[3:1] != 0) err = 1; else nmode[1] = d[3:0];
        8'h0C: begin
          v = d[8:0] & 9'h121;
          if (m_cfg == 4 && (d[0] || d[8])) begin err = 1; v[0] = 0; v[8] = 0; end
          start = v[0] && !m_ctrl[0];
          nctrl = v; cw = 1;
        end
        8'h18: nmask = d[6:0] & 7'h77;
        8'h24: clr = d[6:0];
        8'h28: begin nload[0] = d[15:0]; if (m_cfg < 4) nload[1] = d[31:16]; end
        8'h2C: nload[1] = d[15:0];
        8'h30: begin nmatch[0] = d[15:0]; if (m_cfg < 4) nmatch[1] = d[31:16]; end
        8'h34: nmatch[1] = d[15:0];
        8'h38: npre[0] = d[7:0];
        8'h3C: npre[1] = d[7:0];
        8'h40: npm[0] = d[7:0];
        8'h44: npm[1] = d[7:0];
        default: ;
      endcase
    end
    rl = {m_load[1], m_load[0]};
    if (start) begin
      ncnt = rl; npc = 0;
    end else if (m_ctrl[0] && m_cfg == 0) begin
      if (m_pc == m_pre[0]) begin
        npc = 0;
        if (m_cnt <= 1) begin to = 1; ncnt = m_mode[0][0] ? 32'h0 : rl; end
        else ncnt = m_cnt - 1;
      end else npc = m_pc + 1;
    end
    if (to && m_mode[0][0] && !cw) nctrl[0] = 0;
    if (m_ctrl[0] && m_cfg == 1 && t) begin
      nrtc = m_rtc + 1;
      hit = (nrtc == {m_match[1], m_match[0]});
    end
    @(posedge clk);
    #1;
    m_trig = to && m_ctrl[5];
    m_raw = (m_raw & ~clr) | {4'b0, err, hit, to};
    m_cfg = ncfg; m_ctrl = nctrl; m_mask = nmask; m_cnt = ncnt; m_rtc = nrtc; m_pc = npc;
    m_mode = nmode; m_load = nload; m_match = nmatch; m_pre = npre; m_pm = npm;
    chk(bus_rdata === m_read(a), tag_of(a), bus_rdata, m_read(a));
    chk(irq === |(m_raw & m_mask), "R6 irq", {31'b0, irq}, {31'b0, |(m_raw & m_mask)});
    chk(adc_trig === m_trig, "R4 adc_trig", {31'b0, adc_trig}, {31'b0, m_trig});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1, a, d, 0);
  endtask

  task automatic idle(input int n, input logic [7:0] a);
    for (int i = 0; i < n; i++) step(0, a, 0, 0);
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    step(0, a, 0, 0);
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values
    expect_rd(8'h00, 0, "R1 cfg");
    expect_rd(8'h0C, 0, "R1 ctrl");
    expect_rd(8'h1C, 0, "R1 raw");
    expect_rd(8'h28, 0, "R1 load");
    chk(irq === 1'b0 && adc_trig === 1'b0, "R1 outputs", {30'b0, irq, adc_trig}, 0);

    // R11: prescale registers keep 8 bits
    wr(8'h38, 32'h1FF); expect_rd(8'h38, 32'hFF, "R11 prescale A");
    wr(8'h3C, 32'h12);  expect_rd(8'h3C, 32'h12, "R11 prescale B");
    wr(8'h40, 32'h34);  wr(8'h44, 32'h356);
    expect_rd(8'h40, 32'h34, "R11 pmatch A");
    expect_rd(8'h44, 32'h56, "R11 pmatch B");

    // R8: combined reload and match registers
    wr(8'h28, 32'h0002_0005); expect_rd(8'h28, 32'h0002_0005, "R8 reload wide");
    expect_rd(8'h2C, 32'h2, "R8 reload B");
    wr(8'h30, 32'h3); wr(8'h34, 32'h7);
    expect_rd(8'h30, 32'h0007_0003, "R8 match wide");
    wr(8'h00, 32'h4);
    wr(8'h28, 32'hFFFF_0009); expect_rd(8'h28, 32'h0000_0009, "R8 upper hidden");
    expect_rd(8'h2C, 32'h2, "R8 half B kept");
    wr(8'h00, 32'h0); expect_rd(8'h28, 32'h0002_0009, "R8 upper visible");

    // R9: refused writes
    wr(8'h00, 32'h2); expect_rd(8'h00, 0, "R9 cfg kept");
    expect_rd(8'h1C, 32'h4, "R9 err bit");
    wr(8'h04, 32'hA); expect_rd(8'h04, 0, "R9 mode kept");
    wr(8'h24, 32'h7F); expect_rd(8'h1C, 0, "R7 clear all");

    // R2/R3/R4: periodic countdown with prescale
    wr(8'h18, 32'h1);
    wr(8'h28, 32'h0000_0003);
    wr(8'h38, 32'h1);
    wr(8'h0C, 32'h21);
    idle(5, 8'h48);
    chk(bus_rdata === 32'h1, "R2 count before timeout", bus_rdata, 1);
    step(0, 8'h48, 0, 0);
    chk(bus_rdata === 32'h3, "R3 periodic reload", bus_rdata, 3);
    chk(adc_trig === 1'b1, "R4 trigger pulse", {31'b0, adc_trig}, 1);
    chk(irq === 1'b1, "R6 irq on timeout", {31'b0, irq}, 1);
    step(0, 8'h48, 0, 0);
    chk(adc_trig === 1'b0, "R4 single cycle", {31'b0, adc_trig}, 0);
    idle(20, 8'h48);

    // R7: clear collides with a set
    wr(8'h38, 32'h0); wr(8'h28, 32'h1);
    idle(10, 8'h48);
    wr(8'h24, 32'h1);
    chk(irq === 1'b1, "R7 set wins", {31'b0, irq}, 1);

    // R10: disable freezes, enable reloads
    wr(8'h0C, 32'h0);
    wr(8'h24, 32'h7F);
    expect_rd(8'h48, 32'h1, "R10 frozen");
    idle(4, 8'h48);
    chk(bus_rdata === 32'h1, "R10 still frozen", bus_rdata, 1);
    wr(8'h28, 32'h6);
    wr(8'h0C, 32'h1);
    expect_rd(8'h48, 32'h5, "R10 reload on enable");
    idle(6, 8'h48);

    // R3: one-shot
    wr(8'h0C, 32'h0);
    wr(8'h04, 32'h1);
    wr(8'h28, 32'h2);
    wr(8'h24, 32'h7F);
    wr(8'h0C, 32'h1);
    idle(4, 8'h48);
    chk(bus_rdata === 32'h0, "R3 one-shot count", bus_rdata, 0);
    expect_rd(8'h0C, 32'h0, "R3 one-shot stopped");
    expect_rd(8'h1C, 32'h1, "R3 one-shot timeout flag");

    // R5: RTC mode
    wr(8'h0C, 32'h0);
    wr(8'h00, 32'h1);
    wr(8'h30, 32'h3);
    wr(8'h18, 32'h2);
    wr(8'h24, 32'h7F);
    wr(8'h0C, 32'h21);
    step(0, 8'h48, 0, 1); idle(2, 8'h48);
    step(0, 8'h48, 0, 1); idle(1, 8'h48);
    chk(irq === 1'b0, "R5 no match yet", {31'b0, irq}, 0);
    step(0, 8'h48, 0, 1);
    chk(bus_rdata === 32'h3, "R5 rtc count", bus_rdata, 3);
    chk(irq === 1'b1, "R5 match irq", {31'b0, irq}, 1);
    step(0, 8'h48, 0, 1);
    chk(adc_trig === 1'b0, "R4 no trigger in rtc", {31'b0, adc_trig}, 0);
    wr(8'h0C, 32'h0);
    step(0, 8'h48, 0, 1); step(0, 8'h48, 0, 1);
    chk(bus_rdata === 32'h4, "R5 tick ignored when disabled", bus_rdata, 4);

    // R6: mask write keeps 0x77
    wr(8'h18, 32'hFF); expect_rd(8'h18, 32'h77, "R6 mask bits");
    expect_rd(8'h20, 32'h2, "R6 masked status");

    // R9: enable refused in split config
    wr(8'h00, 32'h4);
    wr(8'h24, 32'h7F);
    wr(8'h0C, 32'h121);
    expect_rd(8'h0C, 32'h20, "R9 enable refused");
    expect_rd(8'h1C, 32'h4, "R9 err on enable");
    idle(3, 8'h48);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule